// File: doc/BRIEF.md
# Asynchronous 16-bit Bus Slave with Interrupt-Acknowledge Responder

This block sits on the card side of a 68000-style asynchronous bus, for example on a RAM expansion board. When the address strobe falls, it classifies the cycle. The cycle is either an access to a small on-card word memory, an interrupt-acknowledge cycle at the block's own level, or a cycle meant for someone else. It answers the first two after a fixed number of wait states. Memory accesses follow the two data strobes lane by lane. An interrupt acknowledge is answered in one of two ways, chosen per cycle by a control pin: the block drives its own vector byte with a data acknowledge, or it raises the valid-peripheral-address line so that the processor takes an autovector.

The strobe/acknowledge pair is the block's only flow control, and the processor applies the back-pressure. The processor keeps the address strobe, data strobes, direction, address and write data stable until it sees the acknowledge. The block in turn keeps its acknowledge, and any read data it drives, asserted until it samples the address strobe high. All inputs are taken as synchronous to `clk`, and every output is registered. Each acknowledge line and each data lane has its own output-enable, which stands in for a tri-state driver.

Top module: `asyncbus_slave`

## Requirements
- R1: After reset, `dtack_oe`, `vpa_oe` and `data_oe` are 0, and `dtack_n` and `vpa_n` are 1.
- R2: For an accepted cycle, the acknowledge (`dtack_n` or `vpa_n` low with its enable high) first appears after clock edge number WAIT_STATES (0..7). Edge 0 is the first rising edge at which `as_n` is sampled low.
- R3: A read with both strobes low, with function code not 111 and with address bits above MEM_AW equal to BASE_PAGE, returns the stored word at index `addr[MEM_AW-1:0]` and drives both lanes (`data_oe` = 11).
- R4: A write updates only the strobed lanes: `uds_n` low writes bits 15..8 and `lds_n` low writes bits 7..0. The other byte keeps its value.
- R5: A byte read drives only the strobed lane: `data_oe[1]` for the upper lane and `data_oe[0]` for the lower lane.
- R6: `data_oe` stays 00 for the whole of a write cycle.
- R7: With `fc` = 111, `addr[2:0]` equal to IRQ_LEVEL, `lds_n` low and `autovec` = 0, the block asserts DTACK, drives `data_oe` = 01 and places VECTOR on `rdata[7:0]`.
- R8: In the same cycle with `autovec` = 1, the block asserts `vpa_n` low instead. DTACK is not driven and `data_oe` stays 00.
- R9: An interrupt acknowledge for another level, or a memory address outside BASE_PAGE, gets no response: all enables stay 0 until the strobe is negated.
- R10: After the edge at which `as_n` is sampled high, the acknowledge line is driven high with its enable still set, and `data_oe` is 00. After the following edge, both acknowledge enables are 0.
- R11: Once given, the acknowledge and the read data stay asserted while `as_n` remains low. DTACK and VPA are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte strobe (bits 15..8), active low |
| lds_n | input | 1 | Lower byte strobe (bits 7..0), active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code; 111 marks interrupt acknowledge |
| addr | input | ABUS_W | Word address bits A[ABUS_W:1] |
| wdata | input | 16 | Write data bus |
| autovec | input | 1 | 1 = answer interrupt acknowledge with VPA |
| rdata | output | 16 | Read data bus value |
| data_oe | output | 2 | Lane drive enables {upper, lower} |
| dtack_n | output | 1 | Data acknowledge, active low |
| dtack_oe | output | 1 | Drive enable for dtack_n |
| vpa_n | output | 1 | Valid peripheral address, active low |
| vpa_oe | output | 1 | Drive enable for vpa_n |

## Verification
The bench builds two copies that share the same stimulus. One has WAIT_STATES = 3 and the other has WAIT_STATES = 0, so every cycle checks the acknowledge edge both for the no-wait path and for the counted path. Both copies use IRQ_LEVEL = 5, VECTOR = 8'h4C, MEM_AW = 4 and the default page. This brings within reach lane-masked writes over a word written earlier, lower-lane-only reads, both ways of answering an acknowledge, and the two kinds of cycle that must be left alone. The bench holds the strobe low for several cycles after the acknowledge, which shows that the block keeps its answer while the processor applies back-pressure.

// File: rtl/asb_pkg.sv
package asb_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_MEM  = 2'd1,
    K_VEC  = 2'd2,
    K_AUTO = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_ACK  = 3'd2,
    S_REL  = 3'd3,
    S_SKIP = 3'd4
  } bus_state_e;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
endpackage

// File: rtl/asb_decode.sv
module asb_decode
  import asb_pkg::*;
#(
  parameter int PAGE_W = 19,
  parameter logic [PAGE_W-1:0] BASE_PAGE = '0,
  parameter int IRQ_LEVEL = 5
) (
  input  logic [2:0]        fc,
  input  logic [PAGE_W-1:0] page,
  input  logic [2:0]        level,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              autovec,
  output cyc_kind_e         kind
);
  localparam logic [2:0] MY_LEVEL = 3'(IRQ_LEVEL);

  always_comb begin
    kind = K_NONE;
    if (fc == FC_CPU_SPACE) begin
      if (level == MY_LEVEL && !lds_n)
        kind = autovec ? K_AUTO : K_VEC;
    end else if (page == BASE_PAGE && !(uds_n && lds_n)) begin
      kind = K_MEM;
    end
  end
endmodule

// File: rtl/asb_mem.sv
module asb_mem #(
  parameter int MEM_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] idx,
  input  logic              wr_en,
  input  logic [1:0]        wr_lanes,
  input  logic [15:0]       wdata,
  output logic [15:0]       rd_word
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [15:0] words [DEPTH];

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) words[i][ln*8 +: 8] <= '0;
      end else if (wr_en && wr_lanes[ln]) begin
        words[idx][ln*8 +: 8] <= wdata[ln*8 +: 8];
      end
    end
  end

  assign rd_word = words[idx];

  // R4
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_lanes != 2'b00));
endmodule

// File: rtl/asb_ctrl.sv
module asb_ctrl
  import asb_pkg::*;
#(
  parameter int WAIT_STATES = 2,
  parameter logic [7:0] VECTOR = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        as_n,
  input  logic        uds_n,
  input  logic        lds_n,
  input  logic        rw,
  input  cyc_kind_e   kind,
  input  logic [15:0] rd_word,
  output logic        wr_en,
  output logic [1:0]  wr_lanes,
  output logic [15:0] rdata,
  output logic [1:0]  data_oe,
  output logic        dtack_n,
  output logic        dtack_oe,
  output logic        vpa_n,
  output logic        vpa_oe
);
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_STATES);

  bus_state_e       state;
  cyc_kind_e        kind_q, kind_eff;
  logic [CNT_W-1:0] cnt;
  logic             ack_now;

  assign kind_eff = (state == S_IDLE) ? kind : kind_q;
  assign ack_now  = !as_n &&
                    ((state == S_IDLE && kind != K_NONE && WAIT_STATES == 0) ||
                     (state == S_WAIT && cnt == WAIT_LIM));
  assign wr_en    = ack_now && kind_eff == K_MEM && !rw;
  assign wr_lanes = {!uds_n, !lds_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind_q   <= K_NONE;
      cnt      <= '0;
      rdata    <= '0;
      data_oe  <= 2'b00;
      dtack_n  <= 1'b1;
      dtack_oe <= 1'b0;
      vpa_n    <= 1'b1;
      vpa_oe   <= 1'b0;
    end else if (ack_now) begin
      state <= S_ACK;
      if (kind_eff == K_AUTO) begin
        vpa_n  <= 1'b0;
        vpa_oe <= 1'b1;
      end else begin
        dtack_n  <= 1'b0;
        dtack_oe <= 1'b1;
        if (kind_eff == K_VEC) begin
          rdata   <= {8'h00, VECTOR};
          data_oe <= 2'b01;
        end else if (rw) begin
          rdata   <= rd_word;
          data_oe <= {!uds_n, !lds_n};
        end
      end
    end else begin
      case (state)
        S_IDLE: if (!as_n) begin
          kind_q <= kind;
          cnt    <= CNT_W'(1);
          state  <= (kind == K_NONE) ? S_SKIP : S_WAIT;
        end
        S_WAIT: if (as_n) state <= S_REL;
                else      cnt   <= cnt + CNT_W'(1);
        S_ACK: if (as_n) begin
          state   <= S_REL;
          dtack_n <= 1'b1;
          vpa_n   <= 1'b1;
          data_oe <= 2'b00;
        end
        S_REL: begin
          dtack_oe <= 1'b0;
          vpa_oe   <= 1'b0;
          state    <= S_IDLE;
        end
        S_SKIP: if (as_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  excl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((dtack_oe && !dtack_n) && (vpa_oe && !vpa_n)));

  // R10
  release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && !dtack_n && as_n) |=> (dtack_oe && dtack_n && data_oe == 2'b00));

  // R10
  release_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dtack_oe && dtack_n) || (vpa_oe && vpa_n)) |=> (!dtack_oe && !vpa_oe));

  // R6
  data_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe != 2'b00) |-> (dtack_oe && !dtack_n));

  // R11
  hold_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && !dtack_n && !as_n) |=> (dtack_oe && !dtack_n));

  // R2
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(!as_n));
endmodule

// File: rtl/asyncbus_slave.sv
module asyncbus_slave
  import asb_pkg::*;
#(
  parameter int ABUS_W = 23,
  parameter int MEM_AW = 4,
  parameter logic [ABUS_W-MEM_AW-1:0] BASE_PAGE = 'h00100,
  parameter int WAIT_STATES = 2,
  parameter int IRQ_LEVEL = 5,
  parameter logic [7:0] VECTOR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw,
  input  logic [2:0]        fc,
  input  logic [ABUS_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              autovec,
  output logic [15:0]       rdata,
  output logic [1:0]        data_oe,
  output logic              dtack_n,
  output logic              dtack_oe,
  output logic              vpa_n,
  output logic              vpa_oe
);
  localparam int PAGE_W = ABUS_W - MEM_AW;

  cyc_kind_e   kind;
  logic        wr_en;
  logic [1:0]  wr_lanes;
  logic [15:0] rd_word;

  asb_decode #(.PAGE_W(PAGE_W), .BASE_PAGE(BASE_PAGE), .IRQ_LEVEL(IRQ_LEVEL)) u_dec (
    .fc(fc), .page(addr[ABUS_W-1:MEM_AW]), .level(addr[2:0]),
    .uds_n(uds_n), .lds_n(lds_n), .autovec(autovec), .kind(kind)
  );

  asb_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .idx(addr[MEM_AW-1:0]), .wr_en(wr_en),
    .wr_lanes(wr_lanes), .wdata(wdata), .rd_word(rd_word)
  );

  asb_ctrl #(.WAIT_STATES(WAIT_STATES), .VECTOR(VECTOR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .kind(kind), .rd_word(rd_word), .wr_en(wr_en),
    .wr_lanes(wr_lanes), .rdata(rdata), .data_oe(data_oe),
    .dtack_n(dtack_n), .dtack_oe(dtack_oe), .vpa_n(vpa_n), .vpa_oe(vpa_oe)
  );
endmodule

// File: tb/asyncbus_slave_test.sv
module asyncbus_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int ABUS_W = 23;
  localparam int MEM_AW = 4;
  localparam logic [ABUS_W-MEM_AW-1:0] PAGE = 'h00100;
  localparam int WS = 3;
  localparam logic [7:0] VEC = 8'h4C;
  localparam int MAX_EDGES = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1, autovec = 1'b0;
  logic [2:0] fc = 3'b101;
  logic [ABUS_W-1:0] addr = '0;
  logic [15:0] wdata = '0;

  logic [15:0] rdata, rdata_z;
  logic [1:0]  data_oe, data_oe_z;
  logic dtack_n, dtack_oe, vpa_n, vpa_oe;
  logic dtack_n_z, dtack_oe_z, vpa_n_z, vpa_oe_z;

  int n_chk = 0, n_bad = 0;

  // Per-cycle observations
  int          k_main, k_zw;
  logic        was_vpa, was_dtack;
  logic [15:0] cap_data;
  logic [1:0]  cap_oe;
  logic        any_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  asyncbus_slave #(.ABUS_W(ABUS_W), .MEM_AW(MEM_AW), .BASE_PAGE(PAGE),
    .WAIT_STATES(WS), .IRQ_LEVEL(5), .VECTOR(VEC)) uut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .fc(fc), .addr(addr), .wdata(wdata), .autovec(autovec),
    .rdata(rdata), .data_oe(data_oe), .dtack_n(dtack_n), .dtack_oe(dtack_oe),
    .vpa_n(vpa_n), .vpa_oe(vpa_oe));

  asyncbus_slave #(.ABUS_W(ABUS_W), .MEM_AW(MEM_AW), .BASE_PAGE(PAGE),
    .WAIT_STATES(0), .IRQ_LEVEL(5), .VECTOR(VEC)) uut_zw (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rw(rw), .fc(fc), .addr(addr), .wdata(wdata), .autovec(autovec),
    .rdata(rdata_z), .data_oe(data_oe_z), .dtack_n(dtack_n_z), .dtack_oe(dtack_oe_z),
    .vpa_n(vpa_n_z), .vpa_oe(vpa_oe_z));

  task automatic check(input string req, input logic ok, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drives one bus cycle, holds the strobe MAX_EDGES edges, then releases it.
  task automatic bus_cycle(input logic r, input logic u, input logic l,
                           input logic [2:0] f, input logic [ABUS_W-1:0] a,
                           input logic [15:0] d, input logic av);
    logic held;
    k_main = -1; k_zw = -1; was_vpa = 0; was_dtack = 0;
    cap_data = '0; cap_oe = '0; any_oe = 0; held = 1;
    @(negedge clk);
    rw = r; uds_n = u; lds_n = l; fc = f; addr = a; wdata = d; autovec = av;
    as_n = 1'b0;
    for (int e = 0; e < MAX_EDGES; e++) begin
      @(negedge clk);
      if (data_oe != 2'b00) any_oe = 1;
      if (k_main < 0 && ((dtack_oe && !dtack_n) || (vpa_oe && !vpa_n))) begin
        k_main = e; was_vpa = vpa_oe && !vpa_n; was_dtack = dtack_oe && !dtack_n;
        cap_data = rdata; cap_oe = data_oe;
      end else if (k_main >= 0) begin
        if (((dtack_oe && !dtack_n) != was_dtack) || ((vpa_oe && !vpa_n) != was_vpa)
            || data_oe != cap_oe || (cap_oe != 0 && rdata != cap_data)) held = 0;
      end
      if (k_zw < 0 && ((dtack_oe_z && !dtack_n_z) || (vpa_oe_z && !vpa_n_z))) k_zw = e;
    end
    // R11: answer held while the strobe stays low
    check("R11", held, "ack held under back-pressure", held, 1);
    check("R11", !(was_vpa && was_dtack), "dtack and vpa together", {was_vpa, was_dtack}, 0);
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    @(negedge clk);
    if (k_main >= 0)
      // R10: driven high, enable still on, data released
      check("R10", dtack_n && vpa_n && data_oe == 0 &&
            (was_dtack ? dtack_oe : vpa_oe), "release first edge",
            {dtack_n, vpa_n, dtack_oe, vpa_oe, data_oe}, 0);
    @(negedge clk);
    // R10: enables off one edge later
    check("R10", !dtack_oe && !vpa_oe && !dtack_oe_z && !vpa_oe_z, "enables off",
          {dtack_oe, vpa_oe, dtack_oe_z, vpa_oe_z}, 0);
  endtask

  function automatic logic [ABUS_W-1:0] mem_addr(input int idx);
    return {PAGE, MEM_AW'(idx)};
  endfunction

  task automatic check_timing(input string req);
    check(req, k_main == WS, "ack edge (WAIT_STATES=3)", k_main, WS);
    check(req, k_zw == 0, "ack edge (WAIT_STATES=0)", k_zw, 0);
  endtask

  task automatic t_reset;
    // R1
    check("R1", !dtack_oe && !vpa_oe && data_oe == 0 && dtack_n && vpa_n,
          "reset outputs", {dtack_oe, vpa_oe, data_oe, dtack_n, vpa_n}, 5'b00011);
  endtask

  task automatic t_full_write_read;
    bus_cycle(0, 0, 0, 3'b101, mem_addr(3), 16'hA55A, 0);
    check_timing("R2");
    check("R6", !any_oe, "data_oe during write", any_oe, 0);
    bus_cycle(1, 0, 0, 3'b101, mem_addr(3), 16'h0000, 0);
    check_timing("R2");
    check("R3", cap_data == 16'hA55A, "word read", cap_data, 16'hA55A);
    check("R3", cap_oe == 2'b11, "both lanes driven", cap_oe, 2'b11);
  endtask

  task automatic t_byte_write;
    bus_cycle(0, 0, 1, 3'b101, mem_addr(3), 16'h12FF, 0);
    check("R6", !any_oe, "data_oe during byte write", any_oe, 0);
    bus_cycle(0, 1, 0, 3'b001, mem_addr(5), 16'hEE77, 0);
    bus_cycle(1, 0, 0, 3'b101, mem_addr(3), 16'h0, 0);
    check("R4", cap_data == 16'h125A, "upper-lane write", cap_data, 16'h125A);
    bus_cycle(1, 0, 0, 3'b101, mem_addr(5), 16'h0, 0);
    check("R4", cap_data == 16'h0077, "lower-lane write", cap_data, 16'h0077);
  endtask

  task automatic t_byte_read;
    bus_cycle(1, 1, 0, 3'b101, mem_addr(3), 16'h0, 0);
    check("R5", cap_oe == 2'b01, "lower byte lane enable", cap_oe, 2'b01);
    check("R5", cap_data[7:0] == 8'h5A, "lower byte", cap_data[7:0], 8'h5A);
    bus_cycle(1, 0, 1, 3'b101, mem_addr(3), 16'h0, 0);
    check("R5", cap_oe == 2'b10, "upper byte lane enable", cap_oe, 2'b10);
    check("R5", cap_data[15:8] == 8'h12, "upper byte", cap_data[15:8], 8'h12);
  endtask

  task automatic t_iack_vector;
    bus_cycle(1, 1, 0, 3'b111, ABUS_W'(5), 16'h0, 0);
    check_timing("R7");
    check("R7", was_dtack && !was_vpa, "vector cycle uses dtack", {was_dtack, was_vpa}, 2'b10);
    check("R7", cap_oe == 2'b01 && cap_data[7:0] == VEC, "vector byte",
          {cap_oe, cap_data[7:0]}, {2'b01, VEC});
  endtask

  task automatic t_iack_auto;
    bus_cycle(1, 1, 0, 3'b111, ABUS_W'(5), 16'h0, 1);
    check_timing("R8");
    check("R8", was_vpa && !was_dtack, "autovector uses vpa", {was_vpa, was_dtack}, 2'b10);
    check("R8", !any_oe, "no data on autovector", any_oe, 0);
  endtask

  task automatic t_ignored;
    bus_cycle(1, 1, 0, 3'b111, ABUS_W'(3), 16'h0, 0);
    check("R9", k_main < 0 && k_zw < 0 && !any_oe, "other level ignored", k_main, -1);
    bus_cycle(0, 0, 0, 3'b101, {PAGE + 1'b1, MEM_AW'(3)}, 16'hDEAD, 0);
    check("R9", k_main < 0 && k_zw < 0 && !any_oe, "foreign page ignored", k_main, -1);
    bus_cycle(1, 0, 0, 3'b101, mem_addr(3), 16'h0, 0);
    check("R9", cap_data == 16'h125A, "foreign-page write left word intact", cap_data, 16'h125A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write_read();
    t_byte_write();
    t_byte_read();
    t_iack_vector();
    t_iack_auto();
    t_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule